// File: doc/BRIEF.md
# Interrupt Controller Command and Setup Port

This block is the byte-wide programming port of one eight-line interrupt unit. A host reaches it through two addresses. A multi-word setup sequence programs the vector base and the nesting and auto-acknowledge modes. Later command bytes end in-service interrupts and move the rotating priority offset. The same port loads the line mask and reads back registers, with an optional poll read that reports and acknowledges the winning line.

The priority resolver, request latches and in-service latches sit next to this block and are not part of it. The block takes their current values as inputs: the request vector, the in-service vector, and the winning line with its valid flag. It returns the resulting control state, a one-cycle clear pulse for the whole unit, a one-hot in-service clear vector, and a poll acknowledge. A separate trigger-mode byte, written through its own strobe and filtered by a fixed per-unit write-enable mask, is kept here as well.

Reads are combinational in the cycle `rd_en` is high and show the state from before that cycle's edge. Every write takes effect at the next rising edge. The pulse outputs (`init_clr`, `isr_clr`, `ack_valid`) are combinational in the cycle of the access.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset, `mask`, `vec_base`, `trig_mode` and `prio_off` are zero, every mode flag is low, and the setup sequence is idle, so an address-1 write loads the mask.
- R2: An address-0 write with bit 4 set pulses `init_clr` in that cycle. At the next edge it clears the mask, vector base, offset and all mode flags, and it leaves `trig_mode` unchanged. It records bit 0 as "mode word follows" and bit 1 as "single unit", and it restarts the setup sequence.
- R3: The first address-1 write after R2 loads `vec_base` with the data ANDed with 0xF8. The sequence then goes to idle if single unit with no mode word, to the mode-word step if single unit with a mode word, and to the cascade-word step otherwise.
- R4: In the cascade-word step an address-1 write changes no output, and `mask` in particular stays unchanged. The sequence then goes to the mode-word step if a mode word was announced, else to idle.
- R5: In the mode-word step an address-1 write sets `sfnm` from bit 4 and `aeoi` from bit 1 and returns to idle. In idle an address-1 write loads `mask`.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control byte. Bit 2 set arms poll. Bit 1 set copies bit 0 into `rd_sel_isr`. Bit 6 set copies bit 5 into `spec_mask`.
- R7: An address-0 write with bits 4 and 3 clear is a command in bits 7:5. Command 0 clears `rot_aeoi` and command 4 sets it.
- R8: Commands 1 and 5 assert the one bit of `isr_clr` for the first set bit of `isr_in`, scanning upward from `prio_off` with wrap. Command 5 also sets `prio_off` to that line plus 1 mod 8. With `isr_in` zero, neither command has any effect.
- R9: Command 3 asserts `isr_clr` for the line in bits 2:0. Command 7 does the same and also sets `prio_off` to that line plus 1 mod 8.
- R10: Command 6 sets `prio_off` to bits 2:0 plus 1 mod 8. Command 2 has no effect.
- R11: With poll armed, a read returns 0x80 OR `win_line` and pulses `ack_valid` with `ack_line` = `win_line` when `win_valid` is high, and returns 0 otherwise. Poll is disarmed at the next edge.
- R12: With poll not armed, an address-0 read returns `isr_in` if `rd_sel_isr` is set and `req_in` otherwise. An address-1 read returns `mask`. `rdata` is 0 when no read is made.
- R13: A `trig_wr` strobe loads `trig_mode` with `wdata` ANDed with the parameter `TRIG_WMASK`. No other access changes `trig_mode`.
- R14: When a poll read and a control-byte write that arms poll fall in the same cycle, the read returns the poll result and poll stays armed afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe for the two-address port |
| rd_en | input | 1 | Read strobe for the two-address port |
| wdata | input | 8 | Write data, shared with the trigger-mode strobe |
| trig_wr | input | 1 | Write strobe for the trigger-mode byte |
| req_in | input | 8 | Current request vector |
| isr_in | input | 8 | Current in-service vector |
| win_valid | input | 1 | A line currently wins arbitration |
| win_line | input | 3 | Winning line number |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| ack_valid | output | 1 | Poll acknowledge pulse |
| ack_line | output | 3 | Line acknowledged by the poll read |
| init_clr | output | 1 | Clear pulse for request and in-service latches |
| isr_clr | output | 8 | One-hot in-service clear |
| mask | output | 8 | Line mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| sfnm | output | 1 | Special fully nested mode |
| aeoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| spec_mask | output | 1 | Special mask mode |
| rd_sel_isr | output | 1 | Address-0 read selects in-service |
| poll_armed | output | 1 | Poll is armed for the next read |
| prio_off | output | 3 | Rotating priority offset |
| trig_mode | output | 8 | Trigger-mode byte |

## Verification
Two things can land in the same cycle. The first pair is a poll read and a write that re-arms poll. The second pair is a setup word and a trigger-mode strobe. Directed steps raise `rd_en` together with an arming control byte, and the bench checks that the read returns the poll result while `poll_armed` stays high. They also send a setup word in the same cycle as `trig_wr`, and the bench checks that the trigger byte takes the filtered data while every other register clears. Random traffic then overlaps reads, port writes and trigger writes freely. The bench's behavioural model judges each cycle, with reads applied before writes.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_e;

    localparam int BIT_SETUP  = 4;
    localparam int BIT_CTRL   = 3;
    localparam int BIT_POLL   = 2;
    localparam int BIT_SELEN  = 1;
    localparam int BIT_SEL    = 0;
    localparam int BIT_SMEN   = 6;
    localparam int BIT_SM     = 5;
    localparam int BIT_NEED4  = 0;
    localparam int BIT_SINGLE = 1;
    localparam int BIT_SFNM   = 4;
    localparam int BIT_AEOI   = 1;

    typedef enum logic [2:0] {
        CMD_ROT_OFF  = 3'd0,
        CMD_EOI      = 3'd1,
        CMD_NOP      = 3'd2,
        CMD_SEOI     = 3'd3,
        CMD_ROT_ON   = 3'd4,
        CMD_REOI     = 3'd5,
        CMD_SETPRI   = 3'd6,
        CMD_RSEOI    = 3'd7
    } cmd_e;

endpackage

// File: rtl/pic_rot_scan.sv
module pic_rot_scan #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    input  logic [LW-1:0]    off,
    output logic             found,
    output logic [LW-1:0]    line
);
    logic [LINES-1:0] rot;
    logic [LW-1:0]    pos;

    for (genvar g = 0; g < LINES; g++) begin : g_rot
        assign rot[g] = vec[LW'(g) + off];
    end

    always_comb begin
        pos = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (rot[i]) pos = LW'(i);
        end
        found = |rot;
        line  = pos + off;
    end

    always_comb begin
        if (!$isunknown(vec) && !$isunknown(off) && found) begin
            assert_scan_hit_R8: assert (vec[line])
                else $error("scan picked a clear line");
        end
    end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic setup_wr,
    input  logic need4_in,
    input  logic single_in,
    input  logic a1_wr,
    output logic ld_base,
    output logic ld_mode,
    output logic ld_mask,
    output seq_e seq_state
);
    typedef struct packed {
        seq_e st;
        logic need4;
        logic single;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        ld_base = 1'b0;
        ld_mode = 1'b0;
        ld_mask = 1'b0;
        if (setup_wr) begin
            s_d.st     = SEQ_BASE;
            s_d.need4  = need4_in;
            s_d.single = single_in;
        end else if (a1_wr) begin
            unique case (s_q.st)
                SEQ_IDLE: ld_mask = 1'b1;
                SEQ_BASE: begin
                    ld_base = 1'b1;
                    if (!s_q.single)    s_d.st = SEQ_CASC;
                    else if (s_q.need4) s_d.st = SEQ_MODE;
                    else                s_d.st = SEQ_IDLE;
                end
                SEQ_CASC: s_d.st = s_q.need4 ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: begin
                    ld_mode = 1'b1;
                    s_d.st  = SEQ_IDLE;
                end
                default: s_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, need4: 1'b0, single: 1'b0};
        else        s_q <= s_d;
    end

    assign seq_state = s_q.st;

    assert_setup_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        setup_wr |=> seq_state == SEQ_BASE);

    assert_mode_to_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_MODE && a1_wr && !setup_wr) |=> seq_state == SEQ_IDLE);

endmodule

// File: rtl/pic_trig_reg.sv
module pic_trig_reg #(
    parameter int DW = 8,
    parameter logic [DW-1:0] WMASK = 8'hF8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (wr) t_d = wdata & WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign q = t_q;

    assert_trig_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));

    assert_trig_filter_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q & ~WMASK) == '0);

endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
    import pic_cmd_pkg::*;
#(
    parameter int DW = 8,
    parameter int LINES = 8,
    parameter logic [DW-1:0] TRIG_WMASK = 8'hF8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    input  logic             trig_wr,
    input  logic [LINES-1:0] req_in,
    input  logic [LINES-1:0] isr_in,
    input  logic             win_valid,
    input  logic [LW-1:0]    win_line,
    output logic [DW-1:0]    rdata,
    output logic             ack_valid,
    output logic [LW-1:0]    ack_line,
    output logic             init_clr,
    output logic [LINES-1:0] isr_clr,
    output logic [LINES-1:0] mask,
    output logic [DW-1:0]    vec_base,
    output logic             sfnm,
    output logic             aeoi,
    output logic             rot_aeoi,
    output logic             spec_mask,
    output logic             rd_sel_isr,
    output logic             poll_armed,
    output logic [LW-1:0]    prio_off,
    output logic [DW-1:0]    trig_mode
);
    localparam logic [DW-1:0] BASE_KEEP = ~DW'(LINES - 1);
    localparam logic [DW-1:0] POLL_FLAG = DW'(1) << (DW - 1);

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic [DW-1:0]    vbase;
        logic             sfnm;
        logic             aeoi;
        logic             rot;
        logic             smm;
        logic             sel;
        logic             poll;
        logic [LW-1:0]    off;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic a0_wr, a1_wr, setup_wr, ctrl_wr, cmd_wr;
    logic ld_base, ld_mode, ld_mask;
    seq_e seq_state;
    logic scan_found;
    logic [LW-1:0] scan_line;
    logic [LW-1:0] arg_line;
    cmd_e cmd;

    assign a0_wr    = wr_en & ~addr;
    assign a1_wr    = wr_en & addr;
    assign setup_wr = a0_wr & wdata[BIT_SETUP];
    assign ctrl_wr  = a0_wr & ~wdata[BIT_SETUP] & wdata[BIT_CTRL];
    assign cmd_wr   = a0_wr & ~wdata[BIT_SETUP] & ~wdata[BIT_CTRL];
    assign cmd      = cmd_e'(wdata[DW-1:DW-3]);
    assign arg_line = wdata[LW-1:0];

    pic_init_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_wr  (setup_wr),
        .need4_in  (wdata[BIT_NEED4]),
        .single_in (wdata[BIT_SINGLE]),
        .a1_wr     (a1_wr),
        .ld_base   (ld_base),
        .ld_mode   (ld_mode),
        .ld_mask   (ld_mask),
        .seq_state (seq_state)
    );

    pic_rot_scan #(.LINES(LINES)) u_scan (
        .vec   (isr_in),
        .off   (ctl_q.off),
        .found (scan_found),
        .line  (scan_line)
    );

    pic_trig_reg #(.DW(DW), .WMASK(TRIG_WMASK)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (trig_wr),
        .wdata (wdata),
        .q     (trig_mode)
    );

    always_comb begin
        ctl_d     = ctl_q;
        isr_clr   = '0;
        init_clr  = 1'b0;
        ack_valid = 1'b0;
        ack_line  = win_line;
        rdata     = '0;

        if (rd_en) begin
            if (ctl_q.poll) begin
                ctl_d.poll = 1'b0;
                if (win_valid) begin
                    ack_valid = 1'b1;
                    rdata     = POLL_FLAG | DW'(win_line);
                end
            end else if (addr) begin
                rdata = DW'(ctl_q.mask);
            end else begin
                rdata = DW'(ctl_q.sel ? isr_in : req_in);
            end
        end

        if (setup_wr) begin
            init_clr = 1'b1;
            ctl_d    = '0;
        end else if (ctrl_wr) begin
            if (wdata[BIT_POLL])  ctl_d.poll = 1'b1;
            if (wdata[BIT_SELEN]) ctl_d.sel  = wdata[BIT_SEL];
            if (wdata[BIT_SMEN])  ctl_d.smm  = wdata[BIT_SM];
        end else if (cmd_wr) begin
            unique case (cmd)
                CMD_ROT_OFF: ctl_d.rot = 1'b0;
                CMD_ROT_ON:  ctl_d.rot = 1'b1;
                CMD_EOI, CMD_REOI: begin
                    if (scan_found) begin
                        isr_clr[scan_line] = 1'b1;
                        if (cmd == CMD_REOI) ctl_d.off = scan_line + LW'(1);
                    end
                end
                CMD_SEOI: isr_clr[arg_line] = 1'b1;
                CMD_RSEOI: begin
                    isr_clr[arg_line] = 1'b1;
                    ctl_d.off = arg_line + LW'(1);
                end
                CMD_SETPRI: ctl_d.off = arg_line + LW'(1);
                default: ;
            endcase
        end

        if (ld_base) ctl_d.vbase = wdata & BASE_KEEP;
        if (ld_mode) begin
            ctl_d.sfnm = wdata[BIT_SFNM];
            ctl_d.aeoi = wdata[BIT_AEOI];
        end
        if (ld_mask) ctl_d.mask = wdata[LINES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mask       = ctl_q.mask;
    assign vec_base   = ctl_q.vbase;
    assign sfnm       = ctl_q.sfnm;
    assign aeoi       = ctl_q.aeoi;
    assign rot_aeoi   = ctl_q.rot;
    assign spec_mask  = ctl_q.smm;
    assign rd_sel_isr = ctl_q.sel;
    assign poll_armed = ctl_q.poll;
    assign prio_off   = ctl_q.off;

    assert_setup_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        setup_wr |=> (mask == '0 && prio_off == '0 && vec_base == '0 && !poll_armed));

    assert_casc_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_CASC && a1_wr) |=> $stable(mask) && $stable(vec_base));

    assert_poll_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && !(ctrl_wr && wdata[BIT_POLL])) |=> !poll_armed);

    assert_poll_rearm_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_armed && ctrl_wr && wdata[BIT_POLL]) |=> poll_armed);

    assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_clr));

    assert_clr_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (cmd == CMD_EOI || cmd == CMD_REOI)) |-> ((isr_clr & ~isr_in) == '0));

    assert_ack_only_polled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (rd_en && poll_armed && win_valid));

endmodule

// File: tb/pic_cmd_if_tb.sv
`timescale 1ns/100ps
module pic_cmd_if_tb;
    localparam logic [7:0] WM = 8'hDE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, trig_wr = 1'b0;
    logic [7:0] wdata = '0, req_in = '0, isr_in = '0;
    logic win_valid = 1'b0;
    logic [2:0] win_line = '0;
    logic [7:0] rdata, isr_clr, mask, vec_base, trig_mode;
    logic ack_valid, init_clr, sfnm, aeoi, rot_aeoi, spec_mask, rd_sel_isr, poll_armed;
    logic [2:0] ack_line, prio_off;

    always #2.5 clk = ~clk;

    pic_cmd_if #(.TRIG_WMASK(WM)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .trig_wr(trig_wr), .req_in(req_in), .isr_in(isr_in),
        .win_valid(win_valid), .win_line(win_line), .rdata(rdata),
        .ack_valid(ack_valid), .ack_line(ack_line), .init_clr(init_clr),
        .isr_clr(isr_clr), .mask(mask), .vec_base(vec_base), .sfnm(sfnm),
        .aeoi(aeoi), .rot_aeoi(rot_aeoi), .spec_mask(spec_mask),
        .rd_sel_isr(rd_sel_isr), .poll_armed(poll_armed), .prio_off(prio_off),
        .trig_mode(trig_mode)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    int m_mask, m_vec, m_sfnm, m_aeoi, m_rot, m_sm, m_sel, m_poll, m_off, m_trig;
    int m_seq, m_need4, m_single;

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int first_from(int v, int off);
        for (int k = 0; k < 8; k++) begin
            if (v[(off + k) % 8]) return (off + k) % 8;
        end
        return -1;
    endfunction

    task automatic model_reset();
        m_mask = 0; m_vec = 0; m_sfnm = 0; m_aeoi = 0; m_rot = 0; m_sm = 0;
        m_sel = 0; m_poll = 0; m_off = 0; m_trig = 0; m_seq = 0; m_need4 = 0; m_single = 0;
    endtask

    task automatic check_comb();
        int e_rd, e_ack, e_clr, e_init, ln, cmd;
        e_rd = 0; e_ack = 0; e_clr = 0; e_init = 0;
        if (rd_en) begin
            if (m_poll) begin
                if (win_valid) begin e_rd = 8'h80 | win_line; e_ack = 1; end
            end else if (addr) e_rd = m_mask;
            else e_rd = m_sel ? isr_in : req_in;
        end
        if (wr_en && !addr) begin
            cmd = wdata[7:5];
            if (wdata[4]) e_init = 1;
            else if (!wdata[3]) begin
                if (cmd == 1 || cmd == 5) begin
                    ln = first_from(isr_in, m_off);
                    if (ln >= 0) e_clr = 1 << ln;
                end else if (cmd == 3 || cmd == 7) e_clr = 1 << wdata[2:0];
            end
        end
        chk("R12 rdata", rdata, e_rd);
        chk("R11 ack_valid", ack_valid, e_ack);
        if (e_ack) chk("R11 ack_line", ack_line, win_line);
        chk("R2 init_clr", init_clr, e_init);
        chk("R8 R9 isr_clr", isr_clr, e_clr);
    endtask

    task automatic model_edge();
        int d, cmd, ln;
        d = wdata;
        if (rd_en && m_poll) m_poll = 0;
        if (wr_en && !addr) begin
            cmd = d >> 5;
            if (d[4]) begin
                m_mask = 0; m_vec = 0; m_sfnm = 0; m_aeoi = 0; m_rot = 0; m_sm = 0;
                m_sel = 0; m_poll = 0; m_off = 0;
                m_seq = 1; m_need4 = d[0]; m_single = d[1];
            end else if (d[3]) begin
                if (d[2]) m_poll = 1;
                if (d[1]) m_sel = d[0];
                if (d[6]) m_sm = d[5];
            end else begin
                case (cmd)
                    0: m_rot = 0;
                    4: m_rot = 1;
                    5: begin ln = first_from(isr_in, m_off); if (ln >= 0) m_off = (ln + 1) % 8; end
                    6: m_off = (d[2:0] + 1) % 8;
                    7: m_off = (d[2:0] + 1) % 8;
                    default: ;
                endcase
            end
        end
        if (wr_en && addr) begin
            case (m_seq)
                0: m_mask = d;
                1: begin m_vec = d & 8'hF8; m_seq = m_single ? (m_need4 ? 3 : 0) : 2; end
                2: m_seq = m_need4 ? 3 : 0;
                default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_seq = 0; end
            endcase
        end
        if (trig_wr) m_trig = d & WM;
    endtask

    task automatic check_regs();
        chk("R5 mask", mask, m_mask);
        chk("R3 vec_base", vec_base, m_vec);
        chk("R5 sfnm", sfnm, m_sfnm);
        chk("R5 aeoi", aeoi, m_aeoi);
        chk("R7 rot_aeoi", rot_aeoi, m_rot);
        chk("R6 spec_mask", spec_mask, m_sm);
        chk("R6 rd_sel_isr", rd_sel_isr, m_sel);
        chk("R6 poll_armed", poll_armed, m_poll);
        chk("R10 prio_off", prio_off, m_off);
        chk("R13 trig_mode", trig_mode, m_trig);
    endtask

    task automatic tick();
        #1;
        check_comb();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_regs();
        wr_en = 0; rd_en = 0; trig_wr = 0;
    endtask

    task automatic wr(bit a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1; tick();
    endtask

    task automatic rd(bit a);
        addr = a; rd_en = 1; tick();
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset mask", mask, 0);
        chk("R1 reset trig", trig_mode, 0);
        chk("R1 reset off", prio_off, 0);
        chk("R1 reset flags", {sfnm, aeoi, rot_aeoi, spec_mask, rd_sel_isr, poll_armed}, 0);
        wr(1, 8'h3C);
        chk("R1 idle loads mask", mask, 8'h3C);

        // R13 trigger byte then setup keeps it
        wdata = 8'hFF; trig_wr = 1; tick();
        chk("R13 trig filtered", trig_mode, WM);
        wr(0, 8'h11);                     // R2 cascaded, mode word follows
        chk("R2 trig kept", trig_mode, WM);
        chk("R2 mask cleared", mask, 0);
        wr(1, 8'h4D);
        chk("R3 base", vec_base, 8'h48);
        wr(1, 8'hFF);                     // cascade word
        chk("R4 cascade ignored", mask, 0);
        wr(1, 8'h12);
        chk("R5 sfnm", sfnm, 1);
        chk("R5 aeoi", aeoi, 1);
        wr(1, 8'hA5);
        chk("R5 mask", mask, 8'hA5);
        rd(1);
        // single unit without mode word, then single with mode word
        wr(0, 8'h12); wr(1, 8'h77); wr(1, 8'h5A);
        chk("R3 single idle", mask, 8'h5A);
        wr(0, 8'h13); wr(1, 8'h88); wr(1, 8'h10);
        chk("R3 single mode", sfnm, 1);

        // R6 / R12 reads
        req_in = 8'h81; isr_in = 8'h3C;
        rd(0);
        wr(0, 8'h0B); rd(0);
        wr(0, 8'h0A); rd(0);
        wr(0, 8'h68); wr(0, 8'h48); wr(0, 8'h09);
        chk("R6 sel gated", rd_sel_isr, 0);

        // R11 poll
        wr(0, 8'h0C); win_valid = 1; win_line = 3'd5; rd(0);
        chk("R11 poll disarmed", poll_armed, 0);
        wr(0, 8'h0C); win_valid = 0; rd(1);

        // R14 overlap: poll read with re-arm write
        wr(0, 8'h0C);
        win_valid = 1; win_line = 3'd2;
        addr = 0; wdata = 8'h0C; wr_en = 1; rd_en = 1; tick();
        chk("R14 poll stays armed", poll_armed, 1);
        rd(0);
        // R14 overlap: setup word with trigger strobe
        addr = 0; wdata = 8'h1D; wr_en = 1; trig_wr = 1; tick();
        chk("R14 trig loaded on setup", trig_mode, 8'h1D & WM);
        wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'h00);

        // R7 R8 R9 R10 commands
        wr(0, 8'h80); chk("R7 rot on", rot_aeoi, 1);
        wr(0, 8'h00); chk("R7 rot off", rot_aeoi, 0);
        wr(0, 8'hC3); chk("R10 setpri", prio_off, 4);
        isr_in = 8'h15; wr(0, 8'h20);
        isr_in = 8'h05; wr(0, 8'hA0); chk("R8 rotate eoi", prio_off, 1);
        isr_in = 8'h00; wr(0, 8'hA0); chk("R8 empty", prio_off, 1);
        wr(0, 8'h66);
        wr(0, 8'hE7); chk("R9 rot specific", prio_off, 0);
        wr(0, 8'h40); chk("R10 nop", prio_off, 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom_range(0, 9) < 8) d[4] = 0;
            addr = 1'($urandom); wdata = d;
            wr_en = ($urandom_range(0, 1) == 1);
            rd_en = ($urandom_range(0, 2) == 0);
            trig_wr = ($urandom_range(0, 9) == 0);
            req_in = 8'($urandom); isr_in = 8'($urandom);
            win_valid = 1'($urandom); win_line = 3'($urandom);
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule